// File: doc/BRIEF.md
# Compare-Match Timer Channel with Selectable Counter Clear

This block is one channel of a general-purpose timer. It holds a 16-bit up-counter that advances by one on every count-enable strobe from an external prescaler. Four compare registers, A to D, are checked against the counter on each strobe. A match raises a one-clock flag for that register. A 3-bit clear-select code picks which event returns the counter to zero. The event can be a match on one of the four registers, or a synchronous-clear pulse from another channel. The code can also disable clearing.

Registers C and D can be switched into buffer mode. In that mode they take no part in comparison, so they raise no flag and cannot clear the counter. When this channel clears its counter on its own selected match, it sends a one-clock pulse on its sync-clear output. Other channels can clear in step from that pulse.

A parameter selects a reduced variant whose clear-select field has only two bits. In that variant the upper code bit is forced to zero, which leaves the codes 000 to 011. All configuration arrives on parallel inputs.

Top module: `cmt_timer`

## Requirements
- R1: While rst_n is low and after its release, count is 0, match_flag is 0000 and sync_clr_out is 0 until the first count or clear event.
- R2: On a clock with cnt_en high and no clear, count becomes count+1 and wraps from 0xFFFF to 0. With cnt_en low and no clear, count holds its value.
- R3: Clear codes 000 and 100 disable clearing. The counter runs through the compare values unchanged.
- R4: With code 001 (or 010), a strobe that finds count equal to register A (or B) loads 0 into the counter instead of incrementing it.
- R5: With buffer mode off, code 101 (or 110) loads 0 on a strobe that finds count equal to register C (or D).
- R6: With buf_mode high, registers C and D produce no match: match_flag[2] and match_flag[3] stay 0, and codes 101 and 110 never clear the counter.
- R7: With code 011 or 111 and sync_en high, count is 0 on the clock after any clock where sync_clr_in is high, whatever cnt_en is. In every other case sync_clr_in is ignored.
- R8: match_flag bit i is 1 for the one clock after each strobe where count equals register i, with bit 0 for A, bit 1 for B, bit 2 for C and bit 3 for D. This holds whatever clear code is selected.
- R9: sync_clr_out is 1 for the one clock after a clear caused by this channel's own selected compare match, and 0 otherwise. A clear caused by sync_clr_in does not raise it.
- R10: With parameter FULL_SEL=0, bit 2 of clr_sel is ignored. Code 101 then behaves as 001, and 111 behaves as 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-enable strobe from the prescaler |
| clr_sel | input | 3 | Clear-source select code |
| sync_en | input | 1 | Allows clearing by another channel |
| buf_mode | input | 1 | Registers C and D act as buffers |
| cmp_a | input | CNT_W | Compare register A |
| cmp_b | input | CNT_W | Compare register B |
| cmp_c | input | CNT_W | Compare register C |
| cmp_d | input | CNT_W | Compare register D |
| sync_clr_in | input | 1 | Synchronous-clear pulse from another channel |
| count | output | CNT_W | Counter value |
| match_flag | output | 4 | Per-register compare-match pulses, bit 0 = A |
| sync_clr_out | output | 1 | Clear pulse for other channels |

## Verification
A wrong clear decision shows on count at the very next clock. The count then reads 0 where it should read the compare value plus one, or the other way round. The error then persists as a shifted period. If the buffer masking fails, match_flag[2] or match_flag[3] rises one clock after the strobe that meets the buffered value. A wrong source for the sync pulse appears on sync_clr_out in that same clock, for example a pulse after a sync-driven clear.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int NUM_REGS = 4;

  // Register index order: 0 = A, 1 = B, 2 = C, 3 = D
  typedef logic [2:0] clr_code_t;

  // Which compare register's match clears the counter for a code
  function automatic logic [NUM_REGS-1:0] clr_mask(input clr_code_t code);
    case (code)
      3'b001:  clr_mask = 4'b0001;
      3'b010:  clr_mask = 4'b0010;
      3'b101:  clr_mask = 4'b0100;
      3'b110:  clr_mask = 4'b1000;
      default: clr_mask = 4'b0000;
    endcase
  endfunction

  // Codes that follow another channel's clear
  function automatic logic is_sync_code(input clr_code_t code);
    is_sync_code = (code[1:0] == 2'b11);
  endfunction
endpackage

// File: rtl/cmt_match_unit.sv
module cmt_match_unit
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cnt_en,
  input  logic                             buf_mode,
  input  logic [CNT_W-1:0]                 count,
  input  logic [NUM_REGS-1:0][CNT_W-1:0]   cmp_vals,
  output logic [NUM_REGS-1:0]              hit,
  output logic [NUM_REGS-1:0]              flag
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
    logic buffered;
    if (i >= 2) begin : g_bufable
      assign buffered = buf_mode;
    end else begin : g_plain
      assign buffered = 1'b0;
    end
    assign hit[i] = cnt_en && !buffered && (count == cmp_vals[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= '0;
    else        flag <= hit;
  end
endmodule

// File: rtl/cmt_clear_sel.sv
module cmt_clear_sel
  import cmt_pkg::*;
#(
  parameter bit FULL_SEL = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          clr_sel,
  input  logic                sync_en,
  input  logic                sync_clr_in,
  input  logic [NUM_REGS-1:0] hit,
  output logic                own_clr,
  output logic                sync_take,
  output logic                sync_clr_out
);
  clr_code_t sel_eff;

  if (FULL_SEL) begin : g_wide
    assign sel_eff = clr_sel;
  end else begin : g_narrow
    assign sel_eff = {1'b0, clr_sel[1:0]};
  end

  assign own_clr   = |(hit & clr_mask(sel_eff));
  assign sync_take = sync_en && is_sync_code(sel_eff) && sync_clr_in;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_clr_out <= 1'b0;
    else        sync_clr_out <= own_clr;
  end
endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic en, input logic zero);
    if (zero)    next_count = '0;
    else if (en) next_count = cur + 1'b1;
    else         next_count = cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, cnt_en, clr);
  end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit FULL_SEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [2:0]       clr_sel,
  input  logic             sync_en,
  input  logic             buf_mode,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  input  logic [CNT_W-1:0] cmp_d,
  input  logic             sync_clr_in,
  output logic [CNT_W-1:0] count,
  output logic [3:0]       match_flag,
  output logic             sync_clr_out
);
  logic [NUM_REGS-1:0][CNT_W-1:0] cmp_vals;
  logic [NUM_REGS-1:0]            hit;
  logic                           own_clr;
  logic                           sync_take;
  logic                           clr_any;

  assign cmp_vals = {cmp_d, cmp_c, cmp_b, cmp_a};
  assign clr_any  = own_clr || sync_take;

  cmt_match_unit #(.CNT_W(CNT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .buf_mode(buf_mode),
    .count(count), .cmp_vals(cmp_vals), .hit(hit), .flag(match_flag)
  );

  cmt_clear_sel #(.FULL_SEL(FULL_SEL)) u_clrsel (
    .clk(clk), .rst_n(rst_n), .clr_sel(clr_sel), .sync_en(sync_en),
    .sync_clr_in(sync_clr_in), .hit(hit), .own_clr(own_clr),
    .sync_take(sync_take), .sync_clr_out(sync_clr_out)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr(clr_any), .count(count)
  );
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             buf_mode,
  input logic             sync_clr_in,
  input logic [CNT_W-1:0] count,
  input logic [3:0]       match_flag,
  input logic             sync_clr_out,
  input logic             own_clr,
  input logic             sync_take
);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !sync_clr_in) |=> $stable(count));

  // R4
  own_clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_clr |=> (count == '0));

  // R7
  sync_clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_take |=> (count == '0));

  // R6
  buf_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_mode |=> (match_flag[3:2] == 2'b00));

  // R8
  flag_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag != 4'b0000) |-> $past(cnt_en));

  // R9
  sync_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr_out |-> (count == '0));
endmodule

bind cmt_timer cmt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .buf_mode(buf_mode),
  .sync_clr_in(sync_clr_in), .count(count), .match_flag(match_flag),
  .sync_clr_out(sync_clr_out), .own_clr(own_clr), .sync_take(sync_take)
);

// File: tb/cmt_timer_tb.sv
module cmt_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [W-1:0] FAR = 16'h8000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnt_en = 1'b0;
  logic [2:0]   clr_sel = 3'b000;
  logic         sync_en = 1'b0;
  logic         buf_mode = 1'b0;
  logic [W-1:0] cmp_a = FAR, cmp_b = FAR, cmp_c = FAR, cmp_d = FAR;
  logic         sync_clr_in = 1'b0;
  logic [W-1:0] count, count_n;
  logic [3:0]   match_flag, match_flag_n;
  logic         sync_clr_out, sync_clr_out_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmt_timer #(.CNT_W(W), .FULL_SEL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr_sel(clr_sel),
    .sync_en(sync_en), .buf_mode(buf_mode), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_c(cmp_c), .cmp_d(cmp_d), .sync_clr_in(sync_clr_in),
    .count(count), .match_flag(match_flag), .sync_clr_out(sync_clr_out)
  );

  cmt_timer #(.CNT_W(W), .FULL_SEL(1'b0)) u_dut_narrow (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr_sel(clr_sel),
    .sync_en(sync_en), .buf_mode(buf_mode), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_c(cmp_c), .cmp_d(cmp_d), .sync_clr_in(sync_clr_in),
    .count(count_n), .match_flag(match_flag_n), .sync_clr_out(sync_clr_out_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: inputs set at the falling edge, outputs sampled after the rising edge
  task automatic step(input logic en, input logic sclr);
    @(negedge clk);
    cnt_en = en;
    sync_clr_in = sclr;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cnt_en = 1'b0; sync_clr_in = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic setup(input logic [2:0] code, input logic s_en, input logic bm,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] d);
    clr_sel = code; sync_en = s_en; buf_mode = bm;
    cmp_a = a; cmp_b = b; cmp_c = c; cmp_d = d;
    do_reset();
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; cnt_en = 1'b1;
    @(posedge clk); #1;
    check("R1 count in reset", count, 0);
    check("R1 flags in reset", match_flag, 0);
    check("R1 sync out in reset", sync_clr_out, 0);
    @(negedge clk); rst_n = 1'b1; cnt_en = 1'b0;
    @(posedge clk); #1;
    check("R1 count after release", count, 0);
  endtask

  task automatic t_count_hold();
    setup(3'b000, 1'b0, 1'b0, FAR, FAR, FAR, FAR);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    check("R2 count after 5 strobes", count, 5);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
    check("R2 count holds without strobe", count, 5);
  endtask

  task automatic t_no_clear();
    logic seen_a;
    setup(3'b000, 1'b0, 1'b0, 16'd3, FAR, FAR, FAR);
    seen_a = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b0);
      if (match_flag[0]) begin
        seen_a = 1'b1;
        check("R8 flag A after strobe at 3", count, 4);
      end
    end
    check("R3 code 000 no clear", count, 10);
    check("R8 flag A raised without clear", seen_a, 1);
    setup(3'b100, 1'b0, 1'b0, FAR, FAR, 16'd2, FAR);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
    check("R3 code 100 no clear", count, 7);
  endtask

  task automatic t_clear_a();
    setup(3'b001, 1'b0, 1'b0, 16'd4, FAR, FAR, FAR);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    check("R4 count reaches A", count, 4);
    check("R9 no sync pulse before match", sync_clr_out, 0);
    step(1'b1, 1'b0);
    check("R4 clear on A", count, 0);
    check("R8 flag A on clear", match_flag, 4'b0001);
    check("R9 sync pulse on own clear", sync_clr_out, 1);
    step(1'b0, 1'b0);
    check("R9 sync pulse one clock", sync_clr_out, 0);
    check("R8 flag one clock", match_flag, 0);
    step(1'b1, 1'b0);
    check("R4 counting resumes", count, 1);
  endtask

  task automatic t_clear_b();
    setup(3'b010, 1'b0, 1'b0, 16'd1, 16'd2, FAR, FAR);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    check("R8 flag A without clear", match_flag, 4'b0001);
    check("R4 no clear on A under 010", count, 2);
    check("R9 no pulse for unselected match", sync_clr_out, 0);
    step(1'b1, 1'b0);
    check("R4 clear on B", count, 0);
    check("R8 flag B", match_flag, 4'b0010);
  endtask

  task automatic t_clear_cd();
    setup(3'b101, 1'b0, 1'b0, FAR, FAR, 16'd3, FAR);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    check("R5 clear on C", count, 0);
    check("R8 flag C", match_flag, 4'b0100);
    setup(3'b110, 1'b0, 1'b0, FAR, FAR, FAR, 16'd5);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
    check("R5 clear on D", count, 0);
    check("R8 flag D", match_flag, 4'b1000);
    check("R9 pulse on D clear", sync_clr_out, 1);
  endtask

  task automatic t_buffer();
    logic seen;
    setup(3'b101, 1'b0, 1'b1, FAR, FAR, 16'd3, 16'd2);
    seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0);
      if (match_flag[3:2] != 2'b00) seen = 1'b1;
    end
    check("R6 buffered C never clears", count, 6);
    check("R6 buffered C/D raise no flag", seen, 0);
    setup(3'b110, 1'b0, 1'b1, FAR, FAR, FAR, 16'd2);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    check("R6 buffered D never clears", count, 5);
  endtask

  task automatic t_sync();
    setup(3'b011, 1'b1, 1'b0, FAR, FAR, FAR, FAR);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    check("R7 sync clear code 011 without strobe", count, 0);
    check("R9 no pulse on sync clear", sync_clr_out, 0);
    setup(3'b111, 1'b1, 1'b0, FAR, FAR, FAR, FAR);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R7 sync clear code 111 beats strobe", count, 0);
    setup(3'b011, 1'b0, 1'b0, FAR, FAR, FAR, FAR);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    check("R7 ignored with sync_en low", count, 3);
    setup(3'b001, 1'b1, 1'b0, FAR, FAR, FAR, FAR);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    check("R7 ignored under code 001", count, 4);
  endtask

  task automatic t_wrap();
    setup(3'b000, 1'b0, 1'b0, FAR, FAR, FAR, FAR);
    for (int i = 0; i < 65535; i++) step(1'b1, 1'b0);
    check("R2 reaches FFFF", count, 16'hFFFF);
    step(1'b1, 1'b0);
    check("R2 wraps to 0", count, 0);
  endtask

  task automatic t_narrow();
    setup(3'b101, 1'b0, 1'b0, 16'd3, FAR, 16'd9, FAR);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
    check("R10 narrow treats 101 as 001", count_n, 0);
    check("R10 wide keeps 101", count, 4);
    check("R10 narrow pulse", sync_clr_out_n, 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_count_hold();
    t_no_clear();
    t_clear_a();
    t_clear_b();
    t_clear_cd();
    t_buffer();
    t_sync();
    t_narrow();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule